// File: doc/BRIEF.md
# DRAM Vref Tap Step Sequencer

This block runs one step of a DRAM data-Vref sweep. A controller hands it a linear tap index, a step-state code and a target chip select. The block splits the tap into a range bit and a 6-bit training value, then issues one or two mode-register-6 writes to the memory controller's operation-command interface. The training-enable bit of each write is set or cleared according to the step state, so that the DRAM enters, stays in, re-enters or leaves Vref training mode.

After each command the block polls the operation interface's status bits and holds off until they read back as zero. If the interface stays busy for longer than a programmable number of samples, the block flags a timeout and carries on with the next command rather than hanging. A continuing step whose next tap would cross the range boundary is promoted by the block itself to a range flip. Training then restarts cleanly in the new range with a disable write followed by an enable write.

Top module: `vref_step_seq`

## Requirements
- R1: The mode-register word has training enable at bit 7, range at bit 6 and value at bits [5:0]. A tap below 23 gives range 1 and value = tap. A tap of 23 or more gives range 0 and value = tap − 23 (taps 0 to 86 are valid).
- R2: Every command word has 0x12 in bits [4:0] and zero in bits [7:5]. Bits [11:8] are 0xE when chip select 0 is chosen (cs_i = 0) and 0xD when chip select 1 is chosen (cs_i = 1).
- R3: A start step (step code 0) or a flip step (step code 2) issues two writes: the first with enable 0 and the second with enable 1.
- R4: An end step (step code 3) issues two writes: the first with enable 1 and the second with enable 0.
- R5: A continuing step (step code 1) issues a single write with enable 1. When tap < 23 and tap + STEP_SIZE ≥ 23, it is instead treated as a flip step (R3).
- R6: After each command the block issues nothing further until it samples op_status_i as all zero. The first sample is taken at the edge that ends the cycle following the command.
- R7: If op_status_i is sampled nonzero poll_limit_i times in a row (a limit of 0 counts as 1), timeout_o is set and the sequence moves on as if the interface had gone idle. timeout_o stays set until the next request is accepted.
- R8: cmd_valid_o rises in the cycle after a request is accepted. done_o is a one-cycle pulse, with busy_o low, in the cycle after the last wait ends. busy_o is high from accept until then.
- R9: req_valid_i is ignored while busy_o is high.
- R10: After reset, busy_o, cmd_valid_o, done_o and timeout_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start a step (taken only when idle) |
| tap_i | input | TAP_W | Linear tap index |
| step_i | input | 2 | Step code: 0 start, 1 continue, 2 flip, 3 end |
| cs_i | input | 1 | Target chip select, 0 or 1 |
| poll_limit_i | input | CNT_W | Busy samples allowed before timeout |
| op_status_i | input | 5 | Operation register bits [4:0] read back |
| busy_o | output | 1 | Step in progress |
| cmd_valid_o | output | 1 | Mode-register word and command valid this cycle |
| mr_word_o | output | 8 | Mode-register-6 training field word |
| cmd_word_o | output | 12 | Operation command word |
| timeout_o | output | 1 | A poll timed out during the current or last step |
| done_o | output | 1 | Step finished (one cycle) |

## Verification
A request driven before edge N shows its first command in the cycle after N. While the command is pending, the bench holds op_status_i nonzero for a chosen number of cycles. It then clears the status and expects the second command, or done_o, in the very next cycle. The timeout case uses a limit of 4. The bench checks that no command and no flag appear in the cycle after the fourth edge following the command. The flag and the next command must appear one cycle later. All sampling happens on the falling edge, with inputs changed there as well.

// File: rtl/vref_seq_pkg.sv
package vref_seq_pkg;
  typedef enum logic [1:0] {
    STEP_START = 2'd0,
    STEP_CONT  = 2'd1,
    STEP_FLIP  = 2'd2,
    STEP_END   = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_st_e;

  localparam int          RANGE_SPLIT = 23;
  localparam logic [4:0]  OP_MR6_WR   = 5'h12;
  localparam logic [3:0]  CS0_SEL     = 4'hE;
  localparam logic [3:0]  CS1_SEL     = 4'hD;
endpackage

// File: rtl/vref_tap_map.sv
module vref_tap_map
  import vref_seq_pkg::*;
#(
  parameter int TAP_W     = 7,
  parameter int STEP_SIZE = 1
) (
  input  logic [TAP_W-1:0] tap_i,
  input  step_e            step_i,
  output logic             range_o,
  output logic [5:0]       value_o,
  output logic             two_o,
  output logic             en_first_o,
  output logic             en_second_o
);
  logic  low_half;
  logic  promote;
  step_e eff_step;

  assign low_half = (32'(tap_i) < RANGE_SPLIT);
  // a continuing step about to cross into the upper range restarts training
  assign promote  = (step_i == STEP_CONT) && low_half &&
                    ((32'(tap_i) + 32'(STEP_SIZE)) >= RANGE_SPLIT);
  assign eff_step = promote ? STEP_FLIP : step_i;

  assign range_o  = low_half;
  assign value_o  = low_half ? 6'(tap_i) : 6'(tap_i - TAP_W'(RANGE_SPLIT));

  always_comb begin
    unique case (eff_step)
      STEP_START, STEP_FLIP: begin two_o = 1'b1; en_first_o = 1'b0; en_second_o = 1'b1; end
      STEP_END:              begin two_o = 1'b1; en_first_o = 1'b1; en_second_o = 1'b0; end
      default:               begin two_o = 1'b0; en_first_o = 1'b1; en_second_o = 1'b1; end
    endcase
  end
endmodule

// File: rtl/vref_poll_timer.sv
module vref_poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim_eff;

  assign lim_eff  = (limit_i == '0) ? (CNT_W+1)'(1) : {1'b0, limit_i};
  assign expire_o = tick_i && (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= lim_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clear_i)              cnt_q <= '0;
    else if (tick_i && !expire_o)  cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/vref_step_seq.sv
module vref_step_seq
  import vref_seq_pkg::*;
#(
  parameter int TAP_W     = 7,
  parameter int STEP_SIZE = 1,
  parameter int CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [1:0]       step_i,
  input  logic             cs_i,
  input  logic [CNT_W-1:0] poll_limit_i,
  input  logic [4:0]       op_status_i,
  output logic             busy_o,
  output logic             cmd_valid_o,
  output logic [7:0]       mr_word_o,
  output logic [11:0]      cmd_word_o,
  output logic             timeout_o,
  output logic             done_o
);
  seq_st_e          st_q;
  logic [TAP_W-1:0] tap_q;
  logic [1:0]       step_q;
  logic             cs_q, phase_q, to_q, done_q;

  logic       rng, two, en_a, en_b, en_cur;
  logic [5:0] val;
  logic       accept, idle_seen, expire, tick, finish_wait;

  vref_tap_map #(.TAP_W(TAP_W), .STEP_SIZE(STEP_SIZE)) u_map (
    .tap_i      (tap_q),
    .step_i     (step_e'(step_q)),
    .range_o    (rng),
    .value_o    (val),
    .two_o      (two),
    .en_first_o (en_a),
    .en_second_o(en_b)
  );

  assign tick      = (st_q == SQ_WAIT) && (op_status_i != 5'd0);
  assign idle_seen = (st_q == SQ_WAIT) && (op_status_i == 5'd0);

  vref_poll_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (st_q == SQ_ISSUE),
    .tick_i  (tick),
    .limit_i (poll_limit_i),
    .expire_o(expire)
  );

  assign accept      = (st_q == SQ_IDLE) && req_valid_i;
  assign finish_wait = idle_seen || expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      tap_q   <= '0;
      step_q  <= '0;
      cs_q    <= 1'b0;
      phase_q <= 1'b0;
      to_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (accept) begin
          tap_q   <= tap_i;
          step_q  <= step_i;
          cs_q    <= cs_i;
          phase_q <= 1'b0;
          to_q    <= 1'b0;
          st_q    <= SQ_ISSUE;
        end
        SQ_ISSUE: st_q <= SQ_WAIT;
        SQ_WAIT: if (finish_wait) begin
          if (expire) to_q <= 1'b1;
          if (two && !phase_q) begin
            phase_q <= 1'b1;
            st_q    <= SQ_ISSUE;
          end else begin
            done_q <= 1'b1;
            st_q   <= SQ_IDLE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign en_cur      = phase_q ? en_b : en_a;
  assign busy_o      = (st_q != SQ_IDLE);
  assign cmd_valid_o = (st_q == SQ_ISSUE);
  assign mr_word_o   = {en_cur, rng, val};
  assign cmd_word_o  = {(cs_q ? CS1_SEL : CS0_SEL), 3'b000, OP_MR6_WR};
  assign timeout_o   = to_q;
  assign done_o      = done_q;
endmodule

// File: rtl/vref_step_seq_chk.sv
module vref_step_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        busy_o,
  input logic        cmd_valid_o,
  input logic [7:0]  mr_word_o,
  input logic [11:0] cmd_word_o,
  input logic        timeout_o,
  input logic        done_o
);
  always_comb begin
    if (!rst_ni) begin
      p_reset_quiet_r10: assert (!busy_o && !cmd_valid_o && !done_o && !timeout_o);
    end
  end

  p_range1_value_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && mr_word_o[6]) |-> (mr_word_o[5:0] < 6'd23));

  p_cmd_format_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_word_o[7:0] == 8'h12 &&
                     (cmd_word_o[11:8] == 4'hE || cmd_word_o[11:8] == 4'hD)));

  p_wait_between_cmds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_timeout_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && !(req_valid_i && !busy_o)) |=> timeout_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_no_cmd_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);
endmodule

bind vref_step_seq vref_step_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .busy_o     (busy_o),
  .cmd_valid_o(cmd_valid_o),
  .mr_word_o  (mr_word_o),
  .cmd_word_o (cmd_word_o),
  .timeout_o  (timeout_o),
  .done_o     (done_o)
);

// File: tb/tb_vref_step_seq.sv
`timescale 1ns/1ps
module tb_vref_step_seq;
  localparam int TAP_W = 7;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [TAP_W-1:0] tap = '0;
  logic [1:0]       step = 2'd0;
  logic             cs = 1'b0;
  logic [CNT_W-1:0] poll_limit = 16'd100;
  logic [4:0]       op_status = 5'd0;
  logic             busy, cmd_valid, timeout, done;
  logic [7:0]       mr_word;
  logic [11:0]      cmd_word;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vref_step_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .tap_i(tap),
    .step_i(step), .cs_i(cs), .poll_limit_i(poll_limit), .op_status_i(op_status),
    .busy_o(busy), .cmd_valid_o(cmd_valid), .mr_word_o(mr_word),
    .cmd_word_o(cmd_word), .timeout_o(timeout), .done_o(done)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mr(input int t, input logic en);
    if (t < 23) return {en, 1'b1, 6'(t)};
    return {en, 1'b0, 6'(t - 23)};
  endfunction

  function automatic logic [11:0] exp_cmd(input logic c);
    return c ? 12'hD12 : 12'hE12;
  endfunction

  // drive a request; returns at the falling edge of the first command cycle (R8)
  task automatic send(input int t, input logic [1:0] s, input logic c);
    @(negedge clk);
    req_valid = 1'b1; tap = TAP_W'(t); step = s; cs = c;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // check the command at this cycle, hold the interface busy d cycles, then release
  task automatic serve(input int t, input logic en, input logic c, input int d,
                       input logic [4:0] stat, input string tag);
    chk(16'(cmd_valid), 16'd1, "R8", "cmd_valid");
    chk(16'(mr_word), 16'(exp_mr(t, en)), tag, "mr_word");
    chk(16'(cmd_word), 16'(exp_cmd(c)), "R2", "cmd_word");
    op_status = stat;
    repeat (d) @(negedge clk);
    chk(16'(cmd_valid), 16'd0, "R6", "no command while interface busy");
    op_status = 5'd0;
    @(negedge clk);
  endtask

  task automatic expect_done(input string tag);
    chk(16'(done), 16'd1, tag, "done pulse");
    chk(16'(busy), 16'd0, "R8", "busy low at done");
    @(negedge clk);
    chk(16'(done), 16'd0, "R8", "done one cycle");
    chk(16'(cmd_valid), 16'd0, "R9", "no extra command");
  endtask

  task automatic t_reset_r10();
    chk(16'({busy, cmd_valid, done, timeout}), 16'd0, "R10", "reset outputs");
  endtask

  task automatic t_start_r3();
    send(30, 2'd0, 1'b1);
    serve(30, 1'b0, 1'b1, 3, 5'h12, "R3");
    serve(30, 1'b1, 1'b1, 2, 5'h01, "R3");
    expect_done("R3");
  endtask

  task automatic t_flip_r3();
    send(5, 2'd2, 1'b0);
    serve(5, 1'b0, 1'b0, 1, 5'h12, "R3");
    serve(5, 1'b1, 1'b0, 1, 5'h12, "R3");
    expect_done("R3");
  endtask

  task automatic t_end_r4();
    send(86, 2'd3, 1'b0);
    serve(86, 1'b1, 1'b0, 2, 5'h10, "R4");
    serve(86, 1'b0, 1'b0, 1, 5'h12, "R4");
    expect_done("R4");
  endtask

  task automatic t_cont_r5();
    send(21, 2'd1, 1'b1);
    serve(21, 1'b1, 1'b1, 2, 5'h12, "R5");
    expect_done("R5");
    send(23, 2'd1, 1'b0);
    serve(23, 1'b1, 1'b0, 1, 5'h12, "R1");
    expect_done("R5");
  endtask

  task automatic t_promote_r5();
    send(22, 2'd1, 1'b0);
    serve(22, 1'b0, 1'b0, 1, 5'h12, "R5");
    serve(22, 1'b1, 1'b0, 1, 5'h12, "R5");
    expect_done("R5");
  endtask

  task automatic t_timeout_r7();
    poll_limit = 16'd4;
    send(10, 2'd0, 1'b0);
    chk(16'(mr_word), 16'(exp_mr(10, 1'b0)), "R1", "first word");
    op_status = 5'h04;
    repeat (4) @(negedge clk);
    chk(16'(cmd_valid), 16'd0, "R7", "still waiting before limit");
    chk(16'(timeout), 16'd0, "R7", "no timeout before limit");
    @(negedge clk);
    chk(16'(timeout), 16'd1, "R7", "timeout raised");
    serve(10, 1'b1, 1'b0, 1, 5'h12, "R7");
    expect_done("R7");
    chk(16'(timeout), 16'd1, "R7", "timeout held after step");
    poll_limit = 16'd100;
    send(40, 2'd1, 1'b1);
    chk(16'(timeout), 16'd0, "R7", "timeout cleared on accept");
    serve(40, 1'b1, 1'b1, 1, 5'h12, "R1");
    expect_done("R7");
  endtask

  task automatic t_ignore_r9();
    send(50, 2'd1, 1'b0);
    chk(16'(mr_word), 16'(exp_mr(50, 1'b1)), "R1", "word");
    op_status = 5'h12;
    req_valid = 1'b1; tap = TAP_W'(3); step = 2'd0; cs = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(16'(cmd_valid), 16'd0, "R9", "request during step ignored");
    op_status = 5'd0;
    @(negedge clk);
    expect_done("R9");
    chk(16'(busy), 16'd0, "R9", "stays idle");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r10();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r10();
    t_start_r3();
    t_flip_r3();
    t_end_r4();
    t_cont_r5();
    t_promote_r5();
    t_timeout_r7();
    t_ignore_r9();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule